// File: doc/BRIEF.md
# Burst-of-Four Late-Write SRAM Core

This block is a synchronous, pipelined memory with one group-address bus and one shared bidirectional data path. A load strobe with a read/write select starts a command. Each command moves exactly four words in two clocks. The double data rate is modelled as two beat lanes, `dq_a` and `dq_b`, that carry two words per clock. The group address picks a block of four words. The two low word bits come from an internal linear counter that runs from word 0 to word 3.

Writes are deferred. Their data arrives on the two clocks after the command and is held in a one-burst pending buffer, with a byte-enable mask for each beat. The buffer is committed to the array by the block itself when the first data pair of the next write arrives. A read is always coherent: for every byte it returns the pending write data where that byte's enable was set, and the array content everywhere else. Read data is driven for two clocks, two clocks after the command. At all other times the core releases the bus.

Top module: `ddr_burst4_sram`

## Requirements
- R1: After reset, `rd_valid` and `proto_err` are low and the core does not drive `dq_a` or `dq_b`.
- R2: A write command accepted at edge E0 samples words 0 and 1 from lanes a and b at edge E1, and words 2 and 3 at edge E2. A later read of the same group returns the words in linear order 0, 1, 2, 3. Every group address, from 0 up to the highest, is usable.
- R3: For a read accepted at edge E0, words 0 and 1 are on lanes a and b in the cycle after E2, and words 2 and 3 in the cycle after E3. `rd_valid` is high in exactly those two cycles.
- R4: Byte-enable bit k of a beat, active high, writes bits [9k+8:9k] of that word. A byte whose enable is low keeps its earlier value.
- R5: A read issued right after a write to the same group, before that write has been committed, returns the new bytes merged with the older bytes of the same word.
- R6: A load strobe on the edge right after an accepted command is ignored. The ignored command moves no data, and `proto_err` is high for the one following cycle.
- R7: A write command on the second or third edge after an accepted read is ignored, so the two cannot fight over the bus. `proto_err` is high for one cycle.
- R8: The core drives the data lanes only while `rd_valid` is high. Values driven by the other side at other times reach the bus unchanged.
- R9: Reads issued every second clock give continuous read data, with `rd_valid` high for four cycles in a row for two reads.
- R10: A pending write is committed to the array when the next write's first data pair arrives. After that, both groups read back their newest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ld | input | 1 | Load strobe that starts a command |
| cmd_rd | input | 1 | 1 selects a read, 0 selects a write |
| grp_addr | input | GROUP_AW | Address of the four-word group |
| ben_a | input | DATA_W/BYTE_W | Byte enables for the lane-a write beat |
| ben_b | input | DATA_W/BYTE_W | Byte enables for the lane-b write beat |
| dq_a | inout | DATA_W | Data lane a: the even word of each beat pair |
| dq_b | inout | DATA_W | Data lane b: the odd word of each beat pair |
| rd_valid | output | 1 | High while the core drives read data |
| proto_err | output | 1 | One-cycle pulse when a load strobe is ignored |

## Verification
The bench reads a group immediately after writing it, so the data must come from the pending buffer. A core without forwarding would return stale array words in that case. Partial byte masks over older data expose a merge done per word instead of per byte, or a swapped enable lane. A load strobe on the busy edge, and a write placed inside the read turnaround window, are each followed by a read-back. A core that let either command through would corrupt the stored data or fail to pulse `proto_err`. Back-to-back reads and a second write to another group expose a lost read address in the pipeline and a commit that fires too early or too late.

// File: rtl/ddr_burst4_sram.sv
module ddr_burst4_sram #(
  parameter int DATA_W   = 36,
  parameter int BYTE_W   = 9,
  parameter int GROUP_AW = 4,
  localparam int NBE     = DATA_W / BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_ld,
  input  logic                cmd_rd,
  input  logic [GROUP_AW-1:0] grp_addr,
  input  logic [NBE-1:0]      ben_a,
  input  logic [NBE-1:0]      ben_b,
  inout  wire  [DATA_W-1:0]   dq_a,
  inout  wire  [DATA_W-1:0]   dq_b,
  output logic                rd_valid,
  output logic                proto_err
);
  localparam int WORDS = 4 << GROUP_AW;

  logic [DATA_W-1:0]   mem [WORDS];
  logic [2:0]          rd_sr;
  logic [1:0]          wr_sr;
  logic [GROUP_AW-1:0] rd_grp, rd_grp2, wr_grp, pend_grp;
  logic [DATA_W-1:0]   pend_dat [4];
  logic [NBE-1:0]      pend_msk [4];
  logic [DATA_W-1:0]   out_a, out_b;

  wire busy     = rd_sr[0] | wr_sr[0];
  wire turn_blk = rd_sr[1] | rd_sr[2];
  wire accept   = cmd_ld && !busy && (cmd_rd || !turn_blk);
  wire rd_acc   = accept && cmd_rd;
  wire wr_acc   = accept && !cmd_rd;

  assign dq_a = rd_valid ? out_a : 'z;
  assign dq_b = rd_valid ? out_b : 'z;

  function automatic logic [DATA_W-1:0] fetch(input logic [GROUP_AW-1:0] g, input logic [1:0] w);
    logic [DATA_W-1:0] v;
    v = mem[{g, w}];
    for (int b = 0; b < NBE; b++)
      if (pend_grp == g && pend_msk[w][b])
        v[b*BYTE_W +: BYTE_W] = pend_dat[w][b*BYTE_W +: BYTE_W];
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sr     <= '0;
      wr_sr     <= '0;
      proto_err <= 1'b0;
      rd_grp    <= '0;
      wr_grp    <= '0;
    end else begin
      rd_sr     <= {rd_sr[1:0], rd_acc};
      wr_sr     <= {wr_sr[0], wr_acc};
      proto_err <= cmd_ld && !accept;
      if (rd_acc) rd_grp <= grp_addr;
      if (wr_acc) wr_grp <= grp_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_sr[0])
      for (int w = 0; w < 4; w++)
        for (int b = 0; b < NBE; b++)
          if (pend_msk[w][b])
            mem[{pend_grp, 2'(w)}][b*BYTE_W +: BYTE_W] <= pend_dat[w][b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_grp <= '0;
      for (int w = 0; w < 4; w++) begin
        pend_dat[w] <= '0;
        pend_msk[w] <= '0;
      end
    end else if (wr_sr[0]) begin
      pend_grp    <= wr_grp;
      pend_dat[0] <= dq_a;
      pend_dat[1] <= dq_b;
      pend_msk[0] <= ben_a;
      pend_msk[1] <= ben_b;
      pend_msk[2] <= '0;
      pend_msk[3] <= '0;
    end else if (wr_sr[1]) begin
      pend_dat[2] <= dq_a;
      pend_dat[3] <= dq_b;
      pend_msk[2] <= ben_a;
      pend_msk[3] <= ben_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      out_a    <= '0;
      out_b    <= '0;
      rd_grp2  <= '0;
    end else begin
      rd_valid <= rd_sr[1] | rd_sr[2];
      if (rd_sr[1]) begin
        out_a   <= fetch(rd_grp, 2'd0);
        out_b   <= fetch(rd_grp, 2'd1);
        rd_grp2 <= rd_grp;
      end else if (rd_sr[2]) begin
        out_a <= fetch(rd_grp2, 2'd2);
        out_b <= fetch(rd_grp2, 2'd3);
      end
    end
  end

  assert_busy_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ld && busy) |=> proto_err);
  assert_err_needs_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(cmd_ld));
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ld && !cmd_rd && turn_blk) |=> proto_err);
  assert_valid_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sr[1] |=> (rd_valid ##1 rd_valid));
  assert_bus_free_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sr[0] || wr_sr[1]) |-> !rd_valid);
  assert_no_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd_sr[1]) && !$past(rd_sr[2])) |-> !rd_valid);
endmodule

// File: tb/tb_ddr_burst4_sram.sv
module tb_ddr_burst4_sram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_ld = 1'b0, cmd_rd = 1'b0;
  logic [3:0] grp_addr = '0;
  logic [3:0] ben_a = '0, ben_b = '0;
  logic [35:0] dqa_drv = '0, dqb_drv = '0;
  logic drv_en = 1'b0;
  wire  [35:0] dq_a, dq_b;
  logic rd_valid, proto_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [35:0] model [64];

  assign dq_a = drv_en ? dqa_drv : 'z;
  assign dq_b = drv_en ? dqb_drv : 'z;

  always #2 clk = ~clk;

  ddr_burst4_sram dut (
    .clk(clk), .rst_n(rst_n), .cmd_ld(cmd_ld), .cmd_rd(cmd_rd), .grp_addr(grp_addr),
    .ben_a(ben_a), .ben_b(ben_b), .dq_a(dq_a), .dq_b(dq_b),
    .rd_valid(rd_valid), .proto_err(proto_err));

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] g, logic [35:0] d0, d1, d2, d3, logic [3:0] m0, m1, m2, m3);
    logic [35:0] d [4];
    logic [3:0]  m [4];
    d = '{d0, d1, d2, d3};
    m = '{m0, m1, m2, m3};
    cmd_ld = 1; cmd_rd = 0; grp_addr = g;
    step();
    cmd_ld = 0; drv_en = 1; dqa_drv = d[0]; dqb_drv = d[1]; ben_a = m[0]; ben_b = m[1];
    step();
    chk("R8 no drive during write", {35'd0, rd_valid}, 36'd0);
    dqa_drv = d[2]; dqb_drv = d[3]; ben_a = m[2]; ben_b = m[3];
    step();
    drv_en = 0; ben_a = 0; ben_b = 0;
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        if (m[w][b]) model[{g, 2'(w)}][b*9 +: 9] = d[w][b*9 +: 9];
  endtask

  task automatic exp_pair(string req, logic [3:0] g, int p);
    chk(req, {35'd0, rd_valid}, 36'd1);
    chk(req, dq_a, model[{g, 2'(2*p)}]);
    chk(req, dq_b, model[{g, 2'(2*p+1)}]);
  endtask

  task automatic do_read(string req, logic [3:0] g);
    cmd_ld = 1; cmd_rd = 1; grp_addr = g;
    step();
    cmd_ld = 0;
    step();
    chk({req, " R3 not early"}, {35'd0, rd_valid}, 36'd0);
    step();
    exp_pair(req, g, 0);
    step();
    exp_pair(req, g, 1);
    step();
    chk({req, " R3 valid two cycles"}, {35'd0, rd_valid}, 36'd0);
  endtask

  task automatic t_reset();
    chk("R1 rd_valid", {35'd0, rd_valid}, 36'd0);
    chk("R1 proto_err", {35'd0, proto_err}, 36'd0);
    drv_en = 1; dqa_drv = 36'h5A5A5A5A5; dqb_drv = 36'hA5A5A5A5A;
    #1;
    chk("R1 R8 lane a free", dq_a, 36'h5A5A5A5A5);
    chk("R1 R8 lane b free", dq_b, 36'hA5A5A5A5A);
    drv_en = 0;
  endtask

  task automatic t_full_and_commit();
    do_write(4'd3, 36'h111111111, 36'h222222222, 36'h333333333, 36'h444444444, 4'hF, 4'hF, 4'hF, 4'hF);
    do_read("R2 R5 linear order from pending", 4'd3);
    do_write(4'd5, 36'hABCDEF012, 36'h0F0F0F0F0, 36'h123456789, 36'hFEDCBA987, 4'hF, 4'hF, 4'hF, 4'hF);
    do_read("R10 committed group", 4'd3);
    do_read("R10 new pending group", 4'd5);
  endtask

  task automatic t_edges();
    do_write(4'd0, 36'h000000001, 36'h000000002, 36'h000000003, 36'h000000004, 4'hF, 4'hF, 4'hF, 4'hF);
    do_write(4'd15, 36'hF00000001, 36'hF00000002, 36'hF00000003, 36'hF00000004, 4'hF, 4'hF, 4'hF, 4'hF);
    do_read("R2 lowest group", 4'd0);
    do_read("R2 highest group", 4'd15);
  endtask

  task automatic t_masks();
    do_write(4'd3, 36'hAAAAAAAAA, 36'hBBBBBBBBB, 36'hCCCCCCCCC, 36'hDDDDDDDDD, 4'b0101, 4'b1000, 4'b0000, 4'b0110);
    do_read("R4 R5 byte merge pending", 4'd3);
    do_write(4'd7, 36'h777777777, 36'h777777777, 36'h777777777, 36'h777777777, 4'hF, 4'hF, 4'hF, 4'hF);
    do_write(4'd7, 36'h0EEEEEEEE, 36'h0EEEEEEEE, 36'h0EEEEEEEE, 36'h0EEEEEEEE, 4'b0001, 4'b0010, 4'b0100, 4'b1000);
    do_read("R4 R5 partial over committed", 4'd7);
    do_read("R4 R10 masked group after commit", 4'd3);
  endtask

  task automatic t_b2b();
    cmd_ld = 1; cmd_rd = 1; grp_addr = 4'd3;
    step();
    cmd_ld = 0;
    step();
    cmd_ld = 1; cmd_rd = 1; grp_addr = 4'd5;
    step();
    cmd_ld = 0;
    exp_pair("R9 first read pair0", 4'd3, 0);
    chk("R9 no error", {35'd0, proto_err}, 36'd0);
    step();
    exp_pair("R9 first read pair1", 4'd3, 1);
    step();
    exp_pair("R9 second read pair0", 4'd5, 0);
    step();
    exp_pair("R9 second read pair1", 4'd5, 1);
    step();
    chk("R9 valid ends", {35'd0, rd_valid}, 36'd0);
  endtask

  task automatic t_busy();
    cmd_ld = 1; cmd_rd = 1; grp_addr = 4'd5;
    step();
    cmd_ld = 1; cmd_rd = 0; grp_addr = 4'd5;
    step();
    cmd_ld = 0;
    chk("R6 error pulse", {35'd0, proto_err}, 36'd1);
    step();
    chk("R6 error one cycle", {35'd0, proto_err}, 36'd0);
    exp_pair("R6 read survives", 4'd5, 0);
    step();
    exp_pair("R6 read survives", 4'd5, 1);
    step();
    do_read("R6 ignored write left data", 4'd5);
  endtask

  task automatic t_turn();
    cmd_ld = 1; cmd_rd = 1; grp_addr = 4'd3;
    step();
    cmd_ld = 0;
    step();
    cmd_ld = 1; cmd_rd = 0; grp_addr = 4'd3;
    step();
    cmd_ld = 0;
    chk("R7 turnaround error", {35'd0, proto_err}, 36'd1);
    exp_pair("R7 read pair0", 4'd3, 0);
    step();
    exp_pair("R7 read pair1", 4'd3, 1);
    chk("R7 error one cycle", {35'd0, proto_err}, 36'd0);
    step();
    do_read("R7 ignored write left data", 4'd3);
    drv_en = 1; dqa_drv = 36'h0C0FFEE00; dqb_drv = 36'h0BADF00D0;
    #1;
    chk("R8 idle lane a", dq_a, 36'h0C0FFEE00);
    chk("R8 idle lane b", dq_b, 36'h0BADF00D0);
    drv_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_full_and_commit();
    t_edges();
    t_masks();
    t_b2b();
    t_busy();
    t_turn();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule